// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block decides which operating mode a CAN protocol controller is in: sleep, initialization, normal or bus-off. It also covers two waiting phases, one after initialization is released and one after a wake-up, in which the controller listens for a clean run of recessive bits before it joins the bus. Software drives a level initialization request, set and clear pulses for a sleep request, and two option bits. One option lets bus-off end without software help. The other lets bus traffic end sleep.

The bit engine supplies the sampled receive line, a strobe at each sample point, a flag that is high while a frame is being sent or received, a start-of-frame pulse and a pulse on entry to bus-off. From these the block produces an initialization acknowledge, a sleep acknowledge, a bus-off flag, a normal-operation enable and the current state of the sleep request. Mode changes requested by software never cut a frame short. Joining the bus always waits for counted recessive runs, and only sample-point strobes advance the counters.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the sleep request is set and the sleep acknowledge is high. The initialization acknowledge, bus-off flag and normal enable are all low.
- R2: While in normal mode, an initialization request takes effect only on the first clock edge at which the frame-activity flag is low. The initialization acknowledge then rises.
- R3: After the initialization request is released, the initialization acknowledge stays high until 11 consecutive recessive samples have been seen. On the edge of the 11th sample, the acknowledge drops and the normal enable rises.
- R4: While in normal mode, a pending sleep request takes effect only when the frame-activity flag is low. The sleep acknowledge then rises.
- R5: A sleep clear pulse during sleep drops the sleep request and the sleep acknowledge on the next edge. Normal mode follows after 11 consecutive recessive samples.
- R6: A dominant sample restarts the recessive run, so the 11 samples must be consecutive.
- R7: With automatic wake-up enabled, a start-of-frame pulse during sleep clears both the sleep request and the sleep acknowledge on the next edge.
- R8: When initialization and sleep are both requested, initialization wins. At most one of the initialization acknowledge, sleep acknowledge, bus-off flag and normal enable is high at any time.
- R9: The recessive counters advance only on clocks where the sample strobe is high. A recessive line without strobes never completes a run.
- R10: A bus-off entry pulse in normal mode raises the bus-off flag and drops the normal enable on the next edge.
- R11: With automatic recovery enabled, bus-off ends after 128 completed runs of 11 recessive samples (1408 samples). The normal enable rises on the edge of the last sample.
- R12: With automatic recovery disabled, recessive samples do not count toward recovery until software has set and then cleared the initialization request while in bus-off. After that, 128 runs of 11 end bus-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req_i | input | 1 | Software initialization request (level) |
| sleep_set_i | input | 1 | Software pulse setting the sleep request |
| sleep_clr_i | input | 1 | Software pulse clearing the sleep request |
| auto_bof_i | input | 1 | Enables automatic bus-off recovery |
| auto_wake_i | input | 1 | Enables wake-up on bus activity |
| rx_i | input | 1 | Sampled receive line, 1 = recessive |
| sample_i | input | 1 | Sample-point strobe |
| busy_i | input | 1 | Frame transmission or reception in progress |
| sof_i | input | 1 | Start-of-frame detect pulse |
| bof_enter_i | input | 1 | Bus-off entry pulse from error logic |
| init_ack_o | output | 1 | Initialization acknowledge |
| sleep_ack_o | output | 1 | Sleep acknowledge |
| bus_off_o | output | 1 | Bus-off indication |
| normal_en_o | output | 1 | Normal operation enable |
| sleep_req_o | output | 1 | Current sleep request state |

## Verification
The assertions assume that a rise of the normal enable or a fall of the bus-off flag is caused by a recessive sample strobe. They also assume the bit engine holds the frame-activity flag steady around a mode change and never pulses start-of-frame together with a software request. The stimulus drives every input at the falling clock edge and keeps the start-of-frame, bus-off and sleep pulses to one cycle each. It never issues a sleep set and a sleep clear in the same cycle, and it raises bus-off entry only while the controller is in normal mode.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    MD_SLEEP  = 3'd0,
    MD_INIT   = 3'd1,
    MD_SYNC   = 3'd2,
    MD_WAKE   = 3'd3,
    MD_NORMAL = 3'd4,
    MD_BUSOFF = 3'd5
  } mode_t;
endpackage

// File: rtl/can_run_det.sv
module can_run_det #(
  parameter int RUN_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sample,
  input  logic rx,
  output logic run_done
);
  localparam int W = (RUN_BITS > 1) ? $clog2(RUN_BITS) : 1;
  localparam logic [W-1:0] LAST = W'(RUN_BITS - 1);

  logic [W-1:0] cnt;

  assign run_done = sample && rx && !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (sample) begin
      if (!rx || cnt == LAST) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/can_recov_cnt.sv
module can_recov_cnt #(
  parameter int RUNS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run_done,
  output logic recov_done
);
  localparam int W = (RUNS > 1) ? $clog2(RUNS) : 1;
  localparam logic [W-1:0] LAST = W'(RUNS - 1);

  logic [W-1:0] cnt;

  assign recov_done = run_done && !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run_done) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic init_req_i,
  input  logic sleep_set_i,
  input  logic sleep_clr_i,
  input  logic auto_bof_i,
  input  logic auto_wake_i,
  input  logic busy_i,
  input  logic sof_i,
  input  logic bof_enter_i,
  input  logic run_done,
  input  logic recov_done,
  output logic run_clr,
  output logic recov_clr,
  output logic init_ack_o,
  output logic sleep_ack_o,
  output logic bus_off_o,
  output logic normal_en_o,
  output logic sleep_req_o
);
  mode_t state, state_nx;
  logic  sleep_q, seen_init, armed;
  logic  hw_wake, sleep_eff;

  assign hw_wake   = (state == MD_SLEEP) && auto_wake_i && sof_i;
  assign sleep_eff = sleep_set_i || (sleep_q && !sleep_clr_i && !hw_wake);

  always_comb begin
    state_nx = state;
    unique case (state)
      MD_SLEEP: begin
        if (init_req_i)              state_nx = MD_INIT;
        else if (!sleep_eff)         state_nx = MD_WAKE;
      end
      MD_INIT: if (!init_req_i)      state_nx = MD_SYNC;
      MD_SYNC, MD_WAKE: begin
        if (init_req_i)              state_nx = MD_INIT;
        else if (run_done)           state_nx = MD_NORMAL;
      end
      MD_NORMAL: begin
        if (bof_enter_i)             state_nx = MD_BUSOFF;
        else if (!busy_i) begin
          if (init_req_i)            state_nx = MD_INIT;
          else if (sleep_eff)        state_nx = MD_SLEEP;
        end
      end
      MD_BUSOFF: if (recov_done)     state_nx = MD_NORMAL;
      default:                       state_nx = MD_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MD_SLEEP;
      sleep_q   <= 1'b1;
      seen_init <= 1'b0;
      armed     <= 1'b0;
    end else begin
      state   <= state_nx;
      sleep_q <= sleep_eff;
      if (state != MD_BUSOFF) begin
        seen_init <= 1'b0;
        armed     <= 1'b0;
      end else begin
        if (init_req_i) seen_init <= 1'b1;
        if (auto_bof_i || (seen_init && !init_req_i)) armed <= 1'b1;
      end
    end
  end

  assign recov_clr = !((state == MD_BUSOFF) && armed);
  assign run_clr   = !((state == MD_SYNC) || (state == MD_WAKE) || !recov_clr);

  assign init_ack_o  = (state == MD_INIT) || (state == MD_SYNC);
  assign sleep_ack_o = (state == MD_SLEEP);
  assign bus_off_o   = (state == MD_BUSOFF);
  assign normal_en_o = (state == MD_NORMAL);
  assign sleep_req_o = sleep_q;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
  parameter int RUN_BITS = 11,
  parameter int RUNS     = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic init_req_i,
  input  logic sleep_set_i,
  input  logic sleep_clr_i,
  input  logic auto_bof_i,
  input  logic auto_wake_i,
  input  logic rx_i,
  input  logic sample_i,
  input  logic busy_i,
  input  logic sof_i,
  input  logic bof_enter_i,
  output logic init_ack_o,
  output logic sleep_ack_o,
  output logic bus_off_o,
  output logic normal_en_o,
  output logic sleep_req_o
);
  logic run_done, recov_done, run_clr, recov_clr;

  can_run_det #(.RUN_BITS(RUN_BITS)) u_run (
    .clk(clk), .rst(rst), .clr(run_clr), .sample(sample_i), .rx(rx_i),
    .run_done(run_done)
  );

  can_recov_cnt #(.RUNS(RUNS)) u_recov (
    .clk(clk), .rst(rst), .clr(recov_clr), .run_done(run_done),
    .recov_done(recov_done)
  );

  can_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .init_req_i(init_req_i), .sleep_set_i(sleep_set_i),
    .sleep_clr_i(sleep_clr_i), .auto_bof_i(auto_bof_i), .auto_wake_i(auto_wake_i),
    .busy_i(busy_i), .sof_i(sof_i), .bof_enter_i(bof_enter_i),
    .run_done(run_done), .recov_done(recov_done),
    .run_clr(run_clr), .recov_clr(recov_clr),
    .init_ack_o(init_ack_o), .sleep_ack_o(sleep_ack_o), .bus_off_o(bus_off_o),
    .normal_en_o(normal_en_o), .sleep_req_o(sleep_req_o)
  );
endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk (
  input logic clk,
  input logic rst,
  input logic init_req_i,
  input logic sleep_set_i,
  input logic sleep_clr_i,
  input logic auto_bof_i,
  input logic auto_wake_i,
  input logic rx_i,
  input logic sample_i,
  input logic busy_i,
  input logic sof_i,
  input logic bof_enter_i,
  input logic init_ack_o,
  input logic sleep_ack_o,
  input logic bus_off_o,
  input logic normal_en_o,
  input logic sleep_req_o
);
  // R8
  one_mode_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({init_ack_o, sleep_ack_o, bus_off_o, normal_en_o}));

  // R2
  init_waits_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (normal_en_o && busy_i && !bof_enter_i) |=> (normal_en_o && !init_ack_o));

  // R4
  sleep_waits_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (normal_en_o && busy_i && !bof_enter_i) |=> !sleep_ack_o);

  // R3
  normal_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(normal_en_o) |-> $past(sample_i && rx_i));

  // R11
  busoff_exit_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_off_o) |-> $past(sample_i && rx_i));

  // R7
  auto_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_ack_o && auto_wake_i && sof_i && !init_req_i && !sleep_set_i)
      |=> (!sleep_ack_o && !sleep_req_o));

  // R10
  busoff_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (normal_en_o && bof_enter_i) |=> (bus_off_o && !normal_en_o));
endmodule

bind can_mode_seq can_mode_chk u_chk (.*);

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_req_i = 0, sleep_set_i = 0, sleep_clr_i = 0, auto_bof_i = 0;
  logic auto_wake_i = 0, rx_i = 1, sample_i = 0, busy_i = 0, sof_i = 0;
  logic bof_enter_i = 0;
  logic init_ack_o, sleep_ack_o, bus_off_o, normal_en_o, sleep_req_o;

  always #10 clk = ~clk;

  can_mode_seq dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string      tag_q[$];
  logic [4:0] exp_q[$];

  // observed vector: {bus_off, normal_en, sleep_ack, init_ack, sleep_req}
  function automatic logic [4:0] obs();
    return {bus_off_o, normal_en_o, sleep_ack_o, init_ack_o, sleep_req_o};
  endfunction

  task automatic expect_v(input string tag, input logic [4:0] e);
    tag_q.push_back(tag);
    exp_q.push_back(e);
    #1;
  endtask

  initial begin
    forever begin
      string t;
      logic [4:0] e;
      wait (exp_q.size() != 0);
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      n_cmp++;
      if (obs() !== e) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b", t, obs(), e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rec(input int n);
    rx_i = 1; sample_i = 1;
    tick(n);
    sample_i = 0;
  endtask

  task automatic dom();
    rx_i = 0; sample_i = 1;
    tick(1);
    sample_i = 0; rx_i = 1;
  endtask

  task automatic pulse_clr();
    sleep_clr_i = 1; tick(1); sleep_clr_i = 0;
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    expect_v("R1 reset state", 5'b00101);

    pulse_clr();
    expect_v("R5 sleep cleared", 5'b00000);
    rx_i = 1; tick(20);
    expect_v("R9 no strobe no run", 5'b00000);
    rec(5); dom(); rec(10);
    expect_v("R6 dominant restarts run", 5'b00000);
    rec(1);
    expect_v("R5 normal after wake run", 5'b01000);

    busy_i = 1; init_req_i = 1; tick(3);
    expect_v("R2 init held by frame", 5'b01000);
    busy_i = 0; tick(1);
    expect_v("R2 init entered", 5'b00010);
    init_req_i = 0; tick(1);
    expect_v("R3 ack held in sync", 5'b00010);
    rec(10);
    expect_v("R3 ack held at 10", 5'b00010);
    rec(1);
    expect_v("R3 normal at 11", 5'b01000);

    busy_i = 1; sleep_set_i = 1; tick(1); sleep_set_i = 0; tick(2);
    expect_v("R4 sleep held by frame", 5'b01001);
    busy_i = 0; tick(1);
    expect_v("R4 sleep entered", 5'b00101);

    auto_wake_i = 1; sof_i = 1; rx_i = 0; tick(1); sof_i = 0; rx_i = 1;
    expect_v("R7 auto wake", 5'b00000);
    auto_wake_i = 0;
    rec(11);
    expect_v("R7 normal after wake", 5'b01000);

    busy_i = 1; init_req_i = 1; sleep_set_i = 1; tick(1); sleep_set_i = 0;
    busy_i = 0; tick(1);
    expect_v("R8 init wins", 5'b00011);
    init_req_i = 0; tick(1); rec(11);
    expect_v("R8 normal with sleep pending", 5'b01001);
    tick(1);
    expect_v("R8 sleep after init", 5'b00101);
    pulse_clr(); rec(11);
    expect_v("R8 back to normal", 5'b01000);

    auto_bof_i = 1; bof_enter_i = 1; tick(1); bof_enter_i = 0;
    expect_v("R10 bus-off entered", 5'b10000);
    tick(1);
    rec(127 * 11);
    expect_v("R11 still bus-off at 127 runs", 5'b10000);
    rec(11);
    expect_v("R11 auto recovery", 5'b01000);

    auto_bof_i = 0; bof_enter_i = 1; tick(1); bof_enter_i = 0;
    expect_v("R10 bus-off again", 5'b10000);
    rec(128 * 11 + 5);
    expect_v("R12 no count without init toggle", 5'b10000);
    init_req_i = 1; tick(2);
    expect_v("R12 init ignored in bus-off", 5'b10000);
    init_req_i = 0; tick(2);
    rec(128 * 11 - 1);
    expect_v("R12 one sample short", 5'b10000);
    rec(1);
    expect_v("R12 gated recovery", 5'b01000);

    tick(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule